// File: doc/BRIEF.md
# Sixteen-Channel Delay Code Register Slave

This block sits on a CAMAC crate dataway as a slave for a programmable sixteen-channel delay module. When its station is selected, it decodes the function code and the subaddress. It keeps one 8-bit delay code per channel. Code N sets that channel's delay to the fixed minimum propagation time plus N/256 of the configured range. All sixteen codes leave the block on a flat parallel bus that wires straight to the delay elements. A newly written code therefore takes effect with no further command.

Function 16 at subaddress x stores the low byte of the write lines into channel x. Function 0 at subaddress x returns channel x's code on the read lines. Both commands answer with the command-accepted (X) and response (Q) lines. Every other function code gets no response and leaves all codes unchanged.

A dataway initialize, or the power-up reset, returns every channel to the minimum delay. A local test input copies a switch-bank value into all channels, so the module can run without a crate controller. The dataway carries no stream, so every pin is a plain level. There is no back-pressure: a write completes in the clock that first sees its strobe.

Top module: `dly_dataway_slave`

## Requirements
- R1: After the power-up reset (rst_n low), all sixteen codes on delay_codes are 0.
- R2: A write needs stn_sel=1 and fcode=16 at the clock edge where strobe1 is first seen high. That edge stores wr_lines[7:0] into channel subaddr, and no other channel changes.
- R3: While stn_sel=1 and fcode=0, rd_lines[7:0] equals the stored code of channel subaddr, combinationally and for the whole cycle, and rd_lines[23:8] is 0. At all other times rd_lines is 0.
- R4: resp_x and resp_q are both 1 exactly when stn_sel=1 and fcode is 0 or 16, at any subaddress 0..15. Otherwise both are 0.
- R5: A strobe with stn_sel=0, or with any fcode other than 0 or 16, changes no code.
- R6: wr_lines[23:8] has no effect on the stored code.
- R7: While init_clr is 1, every code is cleared to 0 at each clock edge. This takes priority over test loads and writes.
- R8: The inhibit input has no effect on reads, writes or responses.
- R9: While test_load is 1 and init_clr is 0, every channel loads switch_code at each clock edge. This takes priority over dataway writes.
- R10: Channel k's code appears on delay_codes[8k+7:8k]. It is updated at the same clock edge that stores it.
- R11: A strobe1 pulse that is held high across several clocks performs exactly one write, using the data present at its first high edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low power-up reset |
| stn_sel | input | 1 | Station select for this slot |
| fcode | input | 5 | Dataway function code |
| subaddr | input | 4 | Dataway subaddress (channel index) |
| strobe1 | input | 1 | First dataway strobe; its rising edge times writes |
| init_clr | input | 1 | Dataway initialize: clears all codes |
| inhibit | input | 1 | Dataway inhibit, deliberately ignored |
| wr_lines | input | 24 | Dataway write lines |
| rd_lines | output | 24 | Dataway read lines |
| resp_x | output | 1 | Command accepted |
| resp_q | output | 1 | Command response |
| test_load | input | 1 | Local test mode: broadcast switch setting |
| switch_code | input | 8 | Local switch-bank delay setting |
| delay_codes | output | 128 | Sixteen 8-bit codes to the delay elements |

## Verification
The bench holds a strobe high across several clocks while it changes the data. A level-triggered write would overwrite the first value with the later one. It sets the upper write lines with the 0xFF and 0x00 codes at subaddresses 0 and 15: a decode that took the wrong byte, or let an index wrap, would land on the wrong channel or value. Function codes 8 and 17, and writes without station select, are strobed. A loose function decode would then corrupt a code or raise X. The bench also asserts init and test load while a write is in progress, which checks the priority order, and it toggles inhibit at random throughout.

// File: rtl/dly_dw_pkg.sv
package dly_dw_pkg;
  localparam int unsigned FN_W = 5;
  localparam logic [FN_W-1:0] FN_READ  = 5'd0;
  localparam logic [FN_W-1:0] FN_WRITE = 5'd16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } dw_op_e;
endpackage

// File: rtl/dw_cmd_decode.sv
module dw_cmd_decode
  import dly_dw_pkg::*;
#(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stn_sel,
  input  logic [FN_W-1:0]   fcode,
  input  logic [ADDR_W-1:0] subaddr,
  input  logic              strobe1,
  output dw_op_e            op,
  output logic              accept,
  output logic              wr_pulse
);
  logic addr_ok;
  logic strobe1_q;

  // A full address space needs no range check; a partial one does.
  generate
    if (CHANNELS == (1 << ADDR_W)) begin : g_full_space
      assign addr_ok = 1'b1;
    end else begin : g_partial_space
      assign addr_ok = (int'(subaddr) < CHANNELS);
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (stn_sel && addr_ok) begin
      if (fcode == FN_READ)       op = OP_READ;
      else if (fcode == FN_WRITE) op = OP_WRITE;
    end
  end

  assign accept = (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe1_q <= 1'b0;
    else        strobe1_q <= strobe1;
  end

  // One write per strobe, on its first sampled high level.
  assign wr_pulse = (op == OP_WRITE) && strobe1 && !strobe1_q;

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R11
  AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> stn_sel && fcode == FN_WRITE); // R5
endmodule

// File: rtl/dw_code_bank.sv
module dw_code_bank #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned BUS_W   = CHANNELS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_all,
  input  logic [CODE_W-1:0] load_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [CODE_W-1:0] wr_data,
  output logic [BUS_W-1:0]  codes
);
  generate
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
      logic hit;
      logic [CODE_W-1:0] code_q;
      assign hit = wr_en && (wr_idx == ADDR_W'(ch));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        code_q <= '0;
        else if (clr)      code_q <= '0;
        else if (load_all) code_q <= load_val;
        else if (hit)      code_q <= wr_data;
      end

      assign codes[ch*CODE_W +: CODE_W] = code_q;
    end
  endgenerate

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> codes == '0); // R7
  AST_TEST_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (load_all && !clr) |=> codes == {CHANNELS{$past(load_val)}}); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !load_all) |=>
      codes[$past(wr_idx)*CODE_W +: CODE_W] == $past(wr_data)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_all && !wr_en) |=> $stable(codes)); // R5
endmodule

// File: rtl/dw_read_mux.sv
module dw_read_mux #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW_W     = 24,
  localparam int unsigned BUS_W   = CHANNELS * CODE_W
) (
  input  logic [BUS_W-1:0]  codes,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DW_W-1:0]   rd_data
);
  logic [CODE_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (rd_idx == ADDR_W'(i)) picked = codes[i*CODE_W +: CODE_W];
    end
  end

  // Lines above the code width stay low; nothing drives the bus when idle.
  assign rd_data = rd_en ? {{(DW_W-CODE_W){1'b0}}, picked} : '0;
endmodule

// File: rtl/dly_dataway_slave.sv
module dly_dataway_slave
  import dly_dw_pkg::*;
#(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW_W     = 24,
  localparam int unsigned BUS_W   = CHANNELS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stn_sel,
  input  logic [FN_W-1:0]   fcode,
  input  logic [ADDR_W-1:0] subaddr,
  input  logic              strobe1,
  input  logic              init_clr,
  input  logic              inhibit,
  input  logic [DW_W-1:0]   wr_lines,
  output logic [DW_W-1:0]   rd_lines,
  output logic              resp_x,
  output logic              resp_q,
  input  logic              test_load,
  input  logic [CODE_W-1:0] switch_code,
  output logic [BUS_W-1:0]  delay_codes
);
  dw_op_e op;
  logic   accept;
  logic   wr_pulse;

  // Inhibit and the upper write lines are intentionally without effect.
  logic ignored_unused;
  assign ignored_unused = ^{inhibit, wr_lines[DW_W-1:CODE_W]};

  dw_cmd_decode #(
    .CHANNELS(CHANNELS),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .stn_sel (stn_sel),
    .fcode   (fcode),
    .subaddr (subaddr),
    .strobe1 (strobe1),
    .op      (op),
    .accept  (accept),
    .wr_pulse(wr_pulse)
  );

  dw_code_bank #(
    .CHANNELS(CHANNELS),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (init_clr),
    .load_all(test_load),
    .load_val(switch_code),
    .wr_en   (wr_pulse),
    .wr_idx  (subaddr),
    .wr_data (wr_lines[CODE_W-1:0]),
    .codes   (delay_codes)
  );

  dw_read_mux #(
    .CHANNELS(CHANNELS),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W),
    .DW_W    (DW_W)
  ) u_rdmux (
    .codes  (delay_codes),
    .rd_en  (op == OP_READ),
    .rd_idx (subaddr),
    .rd_data(rd_lines)
  );

  assign resp_x = accept;
  assign resp_q = accept;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lines[DW_W-1:CODE_W] == '0); // R3
  AST_RD_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(stn_sel && fcode == FN_READ) |-> rd_lines == '0); // R3
  AST_NO_SEL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !stn_sel |-> !resp_x && !resp_q); // R4
  AST_RESET_MIN: assert property (@(posedge clk)
    $rose(rst_n) |-> delay_codes == '0); // R1
endmodule

// File: tb/dly_dataway_slave_bench.sv
module dly_dataway_slave_bench;
  localparam int CH = 16;
  localparam int CW = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stn_sel = 1'b0;
  logic [4:0]   fcode = '0;
  logic [3:0]   subaddr = '0;
  logic         strobe1 = 1'b0;
  logic         init_clr = 1'b0;
  logic         inhibit = 1'b0;
  logic [23:0]  wr_lines = '0;
  logic [23:0]  rd_lines;
  logic         resp_x, resp_q;
  logic         test_load = 1'b0;
  logic [7:0]   switch_code = '0;
  logic [127:0] delay_codes;

  logic [7:0] model [CH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dly_dataway_slave u_dly_dataway_slave (
    .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .fcode(fcode),
    .subaddr(subaddr), .strobe1(strobe1), .init_clr(init_clr),
    .inhibit(inhibit), .wr_lines(wr_lines), .rd_lines(rd_lines),
    .resp_x(resp_x), .resp_q(resp_q), .test_load(test_load),
    .switch_code(switch_code), .delay_codes(delay_codes)
  );

  function automatic bit exp_accept(bit s, logic [4:0] f);
    return s && (f == 5'd0 || f == 5'd16);
  endfunction

  function automatic logic [23:0] exp_read(bit s, logic [4:0] f, logic [3:0] a);
    return (s && f == 5'd0) ? {16'h0, model[a]} : 24'h0;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_codes(string req);
    for (int k = 0; k < CH; k++) begin
      check(delay_codes[k*CW +: CW] == model[k], req,
            delay_codes[k*CW +: CW], model[k]);
    end
  endtask

  task automatic check_resp(string req);
    logic [23:0] er;
    bit ea;
    ea = exp_accept(stn_sel, fcode);
    er = exp_read(stn_sel, fcode, subaddr);
    check(resp_x == ea && resp_q == ea, req, {resp_x, resp_q}, {ea, ea});
    check(rd_lines == er, req, rd_lines, er);
  endtask

  // Full dataway cycle: set lines, check responses, pulse strobe, check codes.
  task automatic dw_cycle(bit s, logic [4:0] f, logic [3:0] a,
                          logic [23:0] d, bit inh);
    @(negedge clk);
    stn_sel = s; fcode = f; subaddr = a; wr_lines = d; inhibit = inh;
    strobe1 = 1'b0;
    #1 check_resp("R4/R3/R8 response");
    @(negedge clk);
    strobe1 = 1'b1;
    @(negedge clk);
    strobe1 = 1'b0;
    if (s && f == 5'd16) model[a] = d[7:0];
    check_codes("R2/R5/R6/R10 codes after strobe");
    #1 check_resp("R3 readback same cycle");
    @(negedge clk);
    stn_sel = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < CH; k++) model[k] = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state visible while held in reset
    check(delay_codes == '0, "R1 codes in reset", delay_codes, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(delay_codes == '0, "R1 codes after reset", delay_codes, 128'h0);
    check(!resp_x && !resp_q && rd_lines == 0, "R4 idle responses",
          {resp_x, resp_q, rd_lines}, 0);

    // Directed: boundary channels, extreme codes, upper lines set (R6)
    dw_cycle(1, 5'd16, 4'd0,  24'hABCDFF, 0);
    dw_cycle(1, 5'd16, 4'd15, 24'hFFFF00, 0);
    dw_cycle(1, 5'd16, 4'd7,  24'h5A5A3C, 1);   // R8 inhibit high
    dw_cycle(1, 5'd0,  4'd0,  24'h0, 0);
    dw_cycle(1, 5'd0,  4'd7,  24'h0, 1);
    dw_cycle(1, 5'd0,  4'd15, 24'hFFFFFF, 0);
    // R5: rejected function codes and missing station select
    dw_cycle(1, 5'd17, 4'd7,  24'h000011, 0);
    dw_cycle(1, 5'd8,  4'd7,  24'h000022, 0);
    dw_cycle(0, 5'd16, 4'd7,  24'h000033, 0);
    dw_cycle(0, 5'd0,  4'd7,  24'h0, 0);

    // R11: strobe held high while data changes
    @(negedge clk);
    stn_sel = 1; fcode = 5'd16; subaddr = 4'd3; wr_lines = 24'h00005A;
    @(negedge clk); strobe1 = 1'b1;
    @(negedge clk); wr_lines = 24'h0000A5;
    @(negedge clk); @(negedge clk);
    model[3] = 8'h5A;
    check(delay_codes[3*CW +: CW] == 8'h5A, "R11 single write per strobe",
          delay_codes[3*CW +: CW], 8'h5A);
    strobe1 = 1'b0; stn_sel = 0;

    // R9: test load overrides a concurrent write
    @(negedge clk);
    stn_sel = 1; fcode = 5'd16; subaddr = 4'd9; wr_lines = 24'h0000EE;
    switch_code = 8'h6B; test_load = 1; strobe1 = 1;
    @(negedge clk);
    test_load = 0; strobe1 = 0; stn_sel = 0;
    for (int k = 0; k < CH; k++) model[k] = 8'h6B;
    check_codes("R9 test load broadcast");

    // R7: init clear beats both test load and write
    @(negedge clk);
    stn_sel = 1; fcode = 5'd16; subaddr = 4'd2; wr_lines = 24'h000077;
    test_load = 1; switch_code = 8'h11; init_clr = 1; strobe1 = 1;
    @(negedge clk);
    init_clr = 0; test_load = 0; strobe1 = 0; stn_sel = 0;
    for (int k = 0; k < CH; k++) model[k] = 8'h0;
    check_codes("R7 init clear priority");

    // Constrained random traffic
    for (int it = 0; it < 400; it++) begin
      logic [4:0] f;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 5)      f = 5'd16;
      else if (pick < 8) f = 5'd0;
      else               f = 5'($urandom_range(0, 31));
      dw_cycle($urandom_range(0, 7) != 0, f, 4'($urandom_range(0, 15)),
               24'($urandom), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule